// File: doc/BRIEF.md
# Gated Edge Event Counter

This block counts edges on one of several asynchronous digital event lines. Configuration inputs choose the line to watch and the edge that counts, which is either rising or falling. The block brings every line into the clock domain with two flip-flops and detects edges on each line separately. It then keeps the edge from the chosen line and adds one to a saturating counter. The counter changes only when the configured qualifying conditions allow it.

Three coupling bits tie the counter to the acquisition machinery around it:
- The first bit freezes counting while acquisition is disabled.
- The second bit qualifies counting by an external gate. A polarity mode sets which gate level allows counts.
- The third bit zeroes the counter whenever the acquisition clear strobe fires.

A host clear strobe always zeroes the counter. The current value is presented continuously on a read port.

Top module: `gated_evt_counter`

## Requirements
- R1: After reset `count_o` is 0.
- R2: With `edge_fall`=0, a 0→1 transition on the selected line is counted exactly once. The new value appears on `count_o` after the third rising clock edge that follows the transition: two synchronizer flops, then the counter register.
- R3: With `edge_fall`=1, only 1→0 transitions are counted, one count per transition. Rising transitions add nothing.
- R4: `src_sel` values 0 to 5 select `src_i[0]` to `src_i[5]`. The lines are aux A, aux B, pileup, risetime reject, analyzer window output and detector reset, in that bit order. Values 6 and 7 mean off and produce no counts.
- R5: A change of `src_sel` never produces a count by itself, whatever levels the lines hold.
- R6: When `cpl_en`=1 and `acq_en`=0, the count holds. When `cpl_en`=0, `acq_en` has no effect.
- R7: When `cpl_gate`=1, `gate_mode` decides which gate level allows counting. Mode 1 counts only while `gate_i`=0, and edges are rejected while the gate is high. Mode 2 counts only while `gate_i`=1. Modes 0 and 3 ignore the gate. When `cpl_gate`=0, the gate has no effect.
- R8: When `cpl_clr`=1, a cycle with `acq_clr`=1 zeroes the count. When `cpl_clr`=0, `acq_clr` has no effect.
- R9: A cycle with `host_clr`=1 zeroes the count. This takes priority over a qualifying edge counted in the same cycle, and that edge is lost.
- R10: At the all-ones value, the counter stays there instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 6 | Asynchronous event lines |
| src_sel | input | 3 | Line select, 6 and 7 mean off |
| edge_fall | input | 1 | 0 counts rising edges, 1 counts falling edges |
| acq_en | input | 1 | Acquisition enable |
| gate_i | input | 1 | External gate level |
| gate_mode | input | 2 | Gate polarity mode |
| cpl_en | input | 1 | Couple counting to `acq_en` |
| cpl_gate | input | 1 | Couple counting to the gate |
| cpl_clr | input | 1 | Couple clearing to `acq_clr` |
| acq_clr | input | 1 | Acquisition clear strobe |
| host_clr | input | 1 | Host clear strobe |
| count_o | output | WIDTH | Current count |

## Verification
The bench switches `src_sel` between lines held at different steady levels. A design that muxes the line before edge detection would count those switches. It also raises `host_clr` in the exact cycle a detected edge reaches the counter. An increment that won over the clear would leave a count of 1 instead of 0. Each coupling bit is tested both set and clear, so a design that ignored a bit, or applied it unconditionally, gives a wrong count. A narrow instance is driven past its all-ones value, where a wrapping counter would return to a small number.

// File: rtl/gated_evt_counter.sv
module gated_evt_counter #(
  parameter int WIDTH = 32,
  parameter int NSRC  = 6,
  parameter int SELW  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_i,
  input  logic [SELW-1:0]  src_sel,
  input  logic             edge_fall,
  input  logic             acq_en,
  input  logic             gate_i,
  input  logic [1:0]       gate_mode,
  input  logic             cpl_en,
  input  logic             cpl_gate,
  input  logic             cpl_clr,
  input  logic             acq_clr,
  input  logic             host_clr,
  output logic [WIDTH-1:0] count_o
);

  localparam logic [WIDTH-1:0] MAXV = {WIDTH{1'b1}};

  logic [NSRC-1:0] meta_q, sync_q, prev_q;
  logic [NSRC-1:0] edges;
  logic            hit, gate_ok, qual, clr;
  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= src_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign edges = edge_fall ? (~sync_q & prev_q) : (sync_q & ~prev_q);

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (src_sel == SELW'(i)) hit = edges[i];
  end

  always_comb begin
    case (gate_mode)
      2'd1:    gate_ok = !gate_i;
      2'd2:    gate_ok = gate_i;
      default: gate_ok = 1'b1;
    endcase
  end

  assign qual = hit && (!cpl_en || acq_en) && (!cpl_gate || gate_ok);
  assign clr  = host_clr || (cpl_clr && acq_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (clr)                   cnt_q <= '0;
    else if (qual && cnt_q != MAXV) cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;

  AST_RESET_ZERO: assert property (@(posedge clk) $rose(rst_n) |-> count_o == '0); // R1
  AST_HOST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    host_clr |=> count_o == '0); // R9
  AST_ACQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_clr && acq_clr) |=> count_o == '0); // R8
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (count_o == $past(count_o) || count_o == $past(count_o) + 1'b1)); // R2
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == MAXV && !clr) |=> count_o == MAXV); // R10
  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel >= SELW'(NSRC) && !clr) |=> $stable(count_o)); // R4
  AST_EN_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_en && !acq_en && !clr) |=> $stable(count_o)); // R6
  AST_GATE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_gate && gate_mode == 2'd1 && gate_i && !clr) |=> $stable(count_o)); // R7

endmodule

// File: tb/gated_evt_counter_test.sv
module gated_evt_counter_test;
  logic clk = 0;
  logic rst_n = 0;
  logic [5:0] src_i = '0;
  logic [2:0] src_sel = '0;
  logic edge_fall = 0, acq_en = 1, gate_i = 0;
  logic [1:0] gate_mode = '0;
  logic cpl_en = 0, cpl_gate = 0, cpl_clr = 0, acq_clr = 0, host_clr = 0;
  logic [31:0] count_o;
  logic [2:0]  small_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gated_evt_counter uut (.clk, .rst_n, .src_i, .src_sel, .edge_fall, .acq_en, .gate_i,
    .gate_mode, .cpl_en, .cpl_gate, .cpl_clr, .acq_clr, .host_clr, .count_o);

  gated_evt_counter #(.WIDTH(3)) uut_sat (.clk, .rst_n, .src_i, .src_sel, .edge_fall,
    .acq_en, .gate_i, .gate_mode, .cpl_en, .cpl_gate, .cpl_clr, .acq_clr, .host_clr,
    .count_o(small_o));

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_line(int idx, logic v);
    @(negedge clk);
    src_i[idx] = v;
    idle(4);
  endtask

  task automatic pulse(int idx);
    set_line(idx, 1'b1);
    set_line(idx, 1'b0);
  endtask

  task automatic hclear();
    @(negedge clk); host_clr = 1;
    @(negedge clk); host_clr = 0;
  endtask

  task automatic t_reset();
    check("R1 reset", count_o, 0);
  endtask

  task automatic t_rising();
    logic [31:0] b;
    hclear(); src_sel = 0; edge_fall = 0;
    b = count_o;
    @(negedge clk); src_i[0] = 1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R2 not before third edge", count_o, b);
    @(negedge clk);
    check("R2 after third edge", count_o, b + 1);
    set_line(0, 1'b0);
    check("R2 falling ignored", count_o, b + 1);
    pulse(0); pulse(0);
    check("R2 three pulses", count_o, b + 3);
  endtask

  task automatic t_falling();
    hclear(); edge_fall = 1; src_sel = 2;
    set_line(2, 1'b1);
    check("R3 rise ignored", count_o, 0);
    set_line(2, 1'b0);
    check("R3 fall counted", count_o, 1);
    edge_fall = 0;
  endtask

  task automatic t_select();
    hclear();
    for (int s = 0; s < 6; s++) begin
      src_sel = 3'(s);
      pulse((s + 1) % 6);
      check("R4 other line ignored", count_o, 32'(s));
      pulse(s);
      check("R4 selected line counted", count_o, 32'(s + 1));
    end
    src_sel = 6; pulse(0); pulse(5);
    src_sel = 7; pulse(3);
    check("R4 off codes", count_o, 6);
  endtask

  task automatic t_switch();
    hclear(); src_sel = 1;
    set_line(0, 1'b1);
    @(negedge clk); src_sel = 0; idle(4);
    @(negedge clk); src_sel = 1; idle(4);
    edge_fall = 1;
    @(negedge clk); src_sel = 0; idle(4);
    @(negedge clk); src_sel = 1; idle(4);
    check("R5 switching no count", count_o, 0);
    edge_fall = 0; set_line(0, 1'b0);
  endtask

  task automatic t_enable();
    hclear(); src_sel = 0;
    cpl_en = 1; acq_en = 0; pulse(0);
    check("R6 frozen", count_o, 0);
    acq_en = 1; pulse(0);
    check("R6 enabled", count_o, 1);
    cpl_en = 0; acq_en = 0; pulse(0);
    check("R6 uncoupled", count_o, 2);
    acq_en = 1;
  endtask

  task automatic t_gate();
    hclear(); src_sel = 0; cpl_gate = 1;
    gate_mode = 1; gate_i = 1; pulse(0);
    check("R7 mode1 high rejects", count_o, 0);
    gate_i = 0; pulse(0);
    check("R7 mode1 low counts", count_o, 1);
    gate_mode = 2; pulse(0);
    check("R7 mode2 low rejects", count_o, 1);
    gate_i = 1; pulse(0);
    check("R7 mode2 high counts", count_o, 2);
    gate_mode = 0; gate_i = 0; pulse(0);
    check("R7 mode0 open", count_o, 3);
    cpl_gate = 0; gate_mode = 1; gate_i = 1; pulse(0);
    check("R7 uncoupled", count_o, 4);
    gate_mode = 0; gate_i = 0;
  endtask

  task automatic t_acqclr();
    hclear(); src_sel = 0; pulse(0); pulse(0);
    cpl_clr = 0;
    @(negedge clk); acq_clr = 1; @(negedge clk); acq_clr = 0;
    check("R8 uncoupled keeps", count_o, 2);
    cpl_clr = 1;
    @(negedge clk); acq_clr = 1; @(negedge clk); acq_clr = 0;
    check("R8 coupled zeroes", count_o, 0);
    cpl_clr = 0;
  endtask

  task automatic t_priority();
    hclear(); src_sel = 0; pulse(0); pulse(0);
    check("R9 preload", count_o, 2);
    @(negedge clk); src_i[0] = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); host_clr = 1;
    @(negedge clk); host_clr = 0;
    check("R9 clear wins", count_o, 0);
    idle(4);
    check("R9 edge lost", count_o, 0);
    set_line(0, 1'b0);
  endtask

  task automatic t_saturate();
    hclear(); src_sel = 0;
    for (int k = 0; k < 9; k++) pulse(0);
    check("R10 saturates", {29'd0, small_o}, 7);
    check("R10 wide keeps counting", count_o, 9);
  endtask

  initial begin
    idle(3);
    t_reset();
    rst_n = 1;
    idle(2);
    t_reset();
    t_rising();
    t_falling();
    t_select();
    t_switch();
    t_enable();
    t_gate();
    t_acqclr();
    t_priority();
    t_saturate();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - bad, total);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - bad, total);
      $finish;
    end
  end
endmodule